// File: doc/BRIEF.md
# Pipelined Low-Precision Dot-Product Unit

This block computes a single dot product between one matrix row and one input vector. The row lives in a small local buffer of 4-bit signed elements and is written ahead of time, eight elements per write. Once a run is started, the vector arrives as a stream of beats, eight 4-bit signed elements per beat, one beat on every clock. Each beat is multiplied lane by lane against the matching row word, and the products are reduced through a registered adder tree and summed into the running total.

Positive and negative products travel on separate paths: two trees and two unsigned accumulators. The signed result is formed by one subtraction at the end. Many copies of this unit, each holding a different row, form a matrix-vector multiplier. With the default eight lanes the result appears a fixed number of cycles after the start: the beat count plus five.

Top module: `dp_dot_unit`

## Requirements
- R1: While and right after synchronous active-low reset, `result_valid` is 0 and `dot_result` is 0.
- R2: When `ld_en` is high at a clock edge, the row word at `ld_addr` takes `ld_data`. Lane l occupies bits [4l+3:4l], so the word holds row elements addr*8+l.
- R3: Matrix and vector elements are 4-bit two's complement. `dot_result` is the 18-bit two's complement sum of the products of row element i and vector element i, over the first `vec_len`*8 elements.
- R4: Positive and negative products are accumulated apart and subtracted at the end. No overflow occurs at the extremes: +65536 for 1024 products of -8 by -8, and -57344 for 1024 products of -8 by 7.
- R5: The vector beat with index b is sampled b clock edges after the edge that accepts `start`, so beat 0 is presented together with `start`. Beats use the same lane layout as R2. Inputs after the last beat have no effect.
- R6: `result_valid` rises exactly `vec_len` + 5 rising edges after the edge that accepted `start`.
- R7: `result_valid` is high for exactly one cycle. `dot_result` holds its value until the next completion.
- R8: A `start` is ignored from the accepting edge up to and including the edge that raises `result_valid`. A `start` presented in the cycle when `result_valid` is high is accepted.
- R9: A `start` with `vec_len` equal to 0 or greater than 128 is ignored and produces no result.
- R10: `vec_len` counts beats of eight elements, from 1 to 128. Both bounds are supported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ld_en | input | 1 | Row word write enable |
| ld_addr | input | 7 | Row word index |
| ld_data | input | 32 | Eight 4-bit row elements |
| start | input | 1 | Begin a dot product |
| vec_len | input | 8 | Number of beats for this run |
| vec_data | input | 32 | Eight 4-bit vector elements, one beat per cycle |
| result_valid | output | 1 | One-cycle completion pulse |
| dot_result | output | 18 | Signed dot product |

## Verification
The bench targets the single-beat run and the full 128-beat run. A design with an off-by-one in its beat counter would drop the last beat or add one extra, and would fire `result_valid` a cycle early or late. Runs with all-extreme operands give the largest positive and the largest negative sums; an accumulator that is too narrow, or that folds the sign in too early, would wrap there. A one-hot vector picks out single row elements at lane and word edges, which exposes lane swaps or a wrong write address. A `start` in the middle of a run, a back-to-back `start` in the pulse cycle, and starts with illegal lengths check that a run is neither restarted, nor lost, nor started falsely.

// File: rtl/dp_pkg.sv
// Package: shared sizing helpers for the dot-product unit.
// Assumes element widths of at least 2 bits.
package dp_pkg;
    // Bits needed for the magnitude of a product of two signed elements
    function automatic int mag_width(input int elem_w);
        return 2 * elem_w - 1;
    endfunction

    // Largest magnitude of one such product
    function automatic longint max_mag(input int elem_w);
        return longint'(1) << (2 * elem_w - 2);
    endfunction
endpackage

// File: rtl/dp_row_store.sv
// Row store: holds one matrix row as DEPTH words of packed elements.
// Synchronous write, synchronous read every cycle; no reset on contents.
module dp_row_store #(
    parameter int WORD_W = 32,
    parameter int DEPTH  = 128,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data
);
    logic [WORD_W-1:0] mem [DEPTH];

    // Write one packed word
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    // Registered read of the addressed word
    always_ff @(posedge clk) begin
        rd_data <= mem[rd_addr];
    end
endmodule

// File: rtl/dp_lane_mul.sv
// Lane multipliers: LANES signed products, each split into a positive
// and a negative magnitude (one of the two is always zero). One register stage.
module dp_lane_mul #(
    parameter int ELEM_W = 4,
    parameter int LANES  = 8,
    localparam int WORD_W = LANES * ELEM_W,
    localparam int MAG_W  = dp_pkg::mag_width(ELEM_W)
) (
    input  logic                   clk,
    input  logic [WORD_W-1:0]      mat_word,
    input  logic [WORD_W-1:0]      vec_word,
    output logic [LANES*MAG_W-1:0] pos_flat,
    output logic [LANES*MAG_W-1:0] neg_flat
);
    genvar l;
    for (l = 0; l < LANES; l++) begin : g_lane
        logic signed [ELEM_W-1:0]   a_s;
        logic signed [ELEM_W-1:0]   b_s;
        logic signed [2*ELEM_W-1:0] prod;
        logic [MAG_W-1:0]           pos_r;
        logic [MAG_W-1:0]           neg_r;

        assign a_s  = mat_word[l*ELEM_W +: ELEM_W];
        assign b_s  = vec_word[l*ELEM_W +: ELEM_W];
        assign prod = a_s * b_s;

        // Route the product magnitude to the path that matches its sign
        always_ff @(posedge clk) begin
            pos_r <= (prod > 0) ? MAG_W'(prod)  : '0;
            neg_r <= (prod < 0) ? MAG_W'(-prod) : '0;
        end

        assign pos_flat[l*MAG_W +: MAG_W] = pos_r;
        assign neg_flat[l*MAG_W +: MAG_W] = neg_r;
    end
endmodule

// File: rtl/dp_adder_tree.sv
// Adder tree: reduces N_IN unsigned inputs to one sum, one register per level.
// Assumes N_IN is a power of two; latency is log2(N_IN) cycles.
module dp_adder_tree #(
    parameter int N_IN = 8,
    parameter int IN_W = 7,
    localparam int DEPTH = $clog2(N_IN),
    localparam int OUT_W = IN_W + DEPTH
) (
    input  logic                 clk,
    input  logic [N_IN*IN_W-1:0] in_flat,
    output logic [OUT_W-1:0]     sum_o
);
    genvar lv, i;
    for (lv = 0; lv <= DEPTH; lv++) begin : g_lvl
        localparam int CNT = N_IN >> lv;
        logic [OUT_W-1:0] node [CNT];
        if (lv == 0) begin : g_in
            for (i = 0; i < CNT; i++) begin : g_ext
                assign node[i] = OUT_W'(in_flat[i*IN_W +: IN_W]);
            end
        end else begin : g_add
            // Add neighbouring pairs from the level below
            always_ff @(posedge clk) begin
                for (int k = 0; k < CNT; k++) begin
                    node[k] <= g_lvl[lv-1].node[2*k] + g_lvl[lv-1].node[2*k+1];
                end
            end
        end
    end

    assign sum_o = g_lvl[DEPTH].node[0];
endmodule

// File: rtl/dp_dot_unit.sv
// Dot-product unit: row buffer, per-lane multipliers, split-sign adder trees
// and accumulators, with control that sequences one run at a time.
// Assumes the vector beats arrive on consecutive cycles, beat 0 with start.
// Latency from the accepting edge to result_valid: beats + 2 + log2(LANES).
module dp_dot_unit #(
    parameter int ELEM_W    = 4,
    parameter int LANES     = 8,
    parameter int MAX_ELEMS = 1024,
    localparam int MAX_BEATS = MAX_ELEMS / LANES,
    localparam int ADDR_W    = $clog2(MAX_BEATS),
    localparam int CNT_W     = $clog2(MAX_BEATS + 1),
    localparam int WORD_W    = LANES * ELEM_W,
    localparam int MAG_W     = dp_pkg::mag_width(ELEM_W),
    localparam int TREE_D    = $clog2(LANES),
    localparam int SUM_W     = MAG_W + TREE_D,
    localparam int ACC_W     = MAG_W + $clog2(MAX_ELEMS),
    localparam int RES_W     = ACC_W + 1,
    localparam int PIPE_N    = TREE_D + 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ld_en,
    input  logic [ADDR_W-1:0]       ld_addr,
    input  logic [WORD_W-1:0]       ld_data,
    input  logic                    start,
    input  logic [CNT_W-1:0]        vec_len,
    input  logic [WORD_W-1:0]       vec_data,
    output logic                    result_valid,
    output logic signed [RES_W-1:0] dot_result
);
    logic                    busy_q;
    logic [CNT_W-1:0]        beat_q;
    logic [CNT_W-1:0]        len_q;
    logic                    accept;
    logic                    feeding;
    logic                    fetch_go;
    logic                    fetch_last;
    logic [ADDR_W-1:0]       fetch_addr;
    logic [WORD_W-1:0]       row_word;
    logic [WORD_W-1:0]       vec_q;
    logic [LANES*MAG_W-1:0]  pos_flat;
    logic [LANES*MAG_W-1:0]  neg_flat;
    logic [SUM_W-1:0]        sum_pos;
    logic [SUM_W-1:0]        sum_neg;
    logic [PIPE_N-1:0]       vld_q;
    logic [PIPE_N-1:0]       last_q;
    logic [ACC_W-1:0]        acc_pos;
    logic [ACC_W-1:0]        acc_neg;
    logic                    fin_q;

    // Start is taken only when idle and with a legal beat count
    assign accept     = start && !busy_q && (vec_len != '0) &&
                        (vec_len <= CNT_W'(MAX_BEATS));
    assign feeding    = busy_q && (beat_q < len_q);
    assign fetch_go   = accept || feeding;
    assign fetch_last = accept ? (vec_len == CNT_W'(1))
                               : (beat_q == len_q - CNT_W'(1));
    assign fetch_addr = accept ? '0 : ADDR_W'(beat_q);

    // Run control: capture the length, step the beat index, end on completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            beat_q <= '0;
            len_q  <= '0;
        end else if (accept) begin
            busy_q <= 1'b1;
            beat_q <= CNT_W'(1);
            len_q  <= vec_len;
        end else begin
            if (feeding) beat_q <= beat_q + CNT_W'(1);
            if (fin_q)   busy_q <= 1'b0;
        end
    end

    dp_row_store #(.WORD_W(WORD_W), .DEPTH(MAX_BEATS)) u_store (
        .clk     (clk),
        .wr_en   (ld_en),
        .wr_addr (ld_addr),
        .wr_data (ld_data),
        .rd_addr (fetch_addr),
        .rd_data (row_word)
    );

    // Fetch stage: register the vector beat alongside the row word read
    always_ff @(posedge clk) begin
        vec_q <= vec_data;
    end

    dp_lane_mul #(.ELEM_W(ELEM_W), .LANES(LANES)) u_mul (
        .clk      (clk),
        .mat_word (row_word),
        .vec_word (vec_q),
        .pos_flat (pos_flat),
        .neg_flat (neg_flat)
    );

    dp_adder_tree #(.N_IN(LANES), .IN_W(MAG_W)) u_tree_pos (
        .clk     (clk),
        .in_flat (pos_flat),
        .sum_o   (sum_pos)
    );

    dp_adder_tree #(.N_IN(LANES), .IN_W(MAG_W)) u_tree_neg (
        .clk     (clk),
        .in_flat (neg_flat),
        .sum_o   (sum_neg)
    );

    // Valid and last flags travel in step with the datapath stages
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q  <= '0;
            last_q <= '0;
        end else begin
            vld_q  <= {vld_q[PIPE_N-2:0], fetch_go};
            last_q <= {last_q[PIPE_N-2:0], fetch_go && fetch_last};
        end
    end

    // Accumulate both sign paths; clear them when a run is accepted
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_pos <= '0;
            acc_neg <= '0;
            fin_q   <= 1'b0;
        end else begin
            fin_q <= vld_q[PIPE_N-1] && last_q[PIPE_N-1];
            if (accept) begin
                acc_pos <= '0;
                acc_neg <= '0;
            end else if (vld_q[PIPE_N-1]) begin
                acc_pos <= acc_pos + ACC_W'(sum_pos);
                acc_neg <= acc_neg + ACC_W'(sum_neg);
            end
        end
    end

    // Output stage: one subtraction forms the signed result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_valid <= 1'b0;
            dot_result   <= '0;
        end else begin
            result_valid <= fin_q;
            if (fin_q) dot_result <= $signed({1'b0, acc_pos}) - $signed({1'b0, acc_neg});
        end
    end
endmodule

// File: rtl/dp_dot_unit_chk.sv
// Checker for the dot-product unit: timing, pulse shape, overflow bound and
// start filtering. Attached to every instance of the top through bind.
module dp_dot_unit_chk #(
    parameter int ELEM_W    = 4,
    parameter int LANES     = 8,
    parameter int MAX_ELEMS = 1024,
    localparam int MAX_BEATS = MAX_ELEMS / LANES,
    localparam int CNT_W     = $clog2(MAX_BEATS + 1),
    localparam int MAG_W     = dp_pkg::mag_width(ELEM_W),
    localparam int ACC_W     = MAG_W + $clog2(MAX_ELEMS),
    localparam int RES_W     = ACC_W + 1,
    localparam int LAT_EXTRA = 2 + $clog2(LANES),
    localparam int LAT_W     = CNT_W + 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    start,
    input logic [CNT_W-1:0]        vec_len,
    input logic                    result_valid,
    input logic signed [RES_W-1:0] dot_result,
    input logic                    busy_q,
    input logic [CNT_W-1:0]        len_q,
    input logic [ACC_W-1:0]        acc_pos,
    input logic [ACC_W-1:0]        acc_neg
);
    localparam longint ACC_MAX = longint'(MAX_ELEMS) * dp_pkg::max_mag(ELEM_W);

    logic [LAT_W-1:0] lat_cnt;

    // Count the cycles a run has been in progress
    always_ff @(posedge clk) begin
        if (!rst_n || !busy_q) lat_cnt <= '0;
        else                   lat_cnt <= lat_cnt + LAT_W'(1);
    end

    AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> (!result_valid && dot_result == '0)); // R1
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (longint'(acc_pos) <= ACC_MAX) && (longint'(acc_neg) <= ACC_MAX)); // R4
    AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> (lat_cnt == LAT_W'(len_q) + LAT_W'(LAT_EXTRA))); // R6
    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |=> !result_valid); // R7
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (result_valid || $stable(dot_result))); // R7
    AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |=> $stable(len_q)); // R8
    AST_BAD_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_q && start && (vec_len == '0 || vec_len > CNT_W'(MAX_BEATS))) |=> !busy_q); // R9
endmodule

bind dp_dot_unit dp_dot_unit_chk #(
    .ELEM_W(ELEM_W), .LANES(LANES), .MAX_ELEMS(MAX_ELEMS)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .vec_len      (vec_len),
    .result_valid (result_valid),
    .dot_result   (dot_result),
    .busy_q       (busy_q),
    .len_q        (len_q),
    .acc_pos      (acc_pos),
    .acc_neg      (acc_neg)
);

// File: tb/dp_dot_unit_bench.sv
`timescale 1ns/1ps
module dp_dot_unit_bench;
    localparam int NE = 1024;
    localparam int NB = 128;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               ld_en = 1'b0;
    logic [6:0]         ld_addr = '0;
    logic [31:0]        ld_data = '0;
    logic               start = 1'b0;
    logic [7:0]         vec_len = '0;
    logic [31:0]        vec_data = '0;
    logic               result_valid;
    logic signed [17:0] dot_result;

    int n_chk = 0;
    int n_bad = 0;
    int row_m [NE];
    int vec_m [NE];

    always #2.5 clk = ~clk;

    dp_dot_unit u_dp_dot_unit (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
        .start(start), .vec_len(vec_len), .vec_data(vec_data),
        .result_valid(result_valid), .dot_result(dot_result)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int rnd4();
        return int'($urandom_range(0, 15)) - 8;
    endfunction

    function automatic int expect_dot(input int nb);
        int s = 0;
        for (int i = 0; i < nb * 8; i++) s += row_m[i] * vec_m[i];
        return s;
    endfunction

    function automatic logic [31:0] pack_row(input int w);
        logic [31:0] v;
        for (int l = 0; l < 8; l++) v[l*4 +: 4] = 4'(row_m[w*8 + l]);
        return v;
    endfunction

    function automatic logic [31:0] pack_vec(input int b);
        logic [31:0] v;
        for (int l = 0; l < 8; l++) v[l*4 +: 4] = 4'(vec_m[b*8 + l]);
        return v;
    endfunction

    task automatic write_row();
        for (int w = 0; w < NB; w++) begin
            @(negedge clk);
            ld_en = 1'b1; ld_addr = 7'(w); ld_data = pack_row(w);
        end
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    // Drive one run and check value, timing and hold; optional injected start
    task automatic do_run(input int nb, input bit no_wait, input bit ret_early,
                          input int inj_at, input int inj_len, input string req);
        int  exp = expect_dot(nb);
        bit  timing_ok = 1'b1;
        int  seen_at = -1;
        for (int c = 0; c <= nb + 7; c++) begin
            if (!(no_wait && c == 0)) @(negedge clk);
            if (c > 0) begin
                if (result_valid && seen_at < 0) seen_at = c - 1;
                if (result_valid != (c - 1 == nb + 5)) timing_ok = 1'b0;
            end
            if (c == nb + 6)
                check(result_valid && dot_result == 18'(exp), {req, " R3 value"}, int'(dot_result), exp);
            if (c == nb + 7)
                check(!result_valid && dot_result == 18'(exp), "R7 pulse/hold", int'(dot_result), exp);
            if (ret_early && c == nb + 6) break;
            start    = (c == 0) || (c == inj_at);
            vec_len  = (c == 0) ? 8'(nb) : 8'(inj_len);
            vec_data = (c < nb) ? pack_vec(c) : $urandom();
        end
        check(timing_ok, "R6 latency", seen_at, nb + 5);
    endtask

    task automatic bad_start(input int len);
        bit quiet = 1'b1;
        @(negedge clk);
        start = 1'b1; vec_len = 8'(len); vec_data = $urandom();
        @(negedge clk);
        start = 1'b0;
        for (int c = 0; c < 140; c++) begin
            @(negedge clk);
            if (result_valid) quiet = 1'b0;
        end
        check(quiet, "R9 illegal length ignored", int'(quiet), 1);
    endtask

    task automatic fill_row_rand();
        for (int i = 0; i < NE; i++) row_m[i] = rnd4();
        write_row();
    endtask

    task automatic fill_vec_rand();
        for (int i = 0; i < NE; i++) vec_m[i] = rnd4();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        check(!result_valid && dot_result == '0, "R1 reset state", int'(dot_result), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!result_valid && dot_result == '0, "R1 after reset", int'(dot_result), 0);

        // R2: one-hot vectors pick single row elements at lane/word edges
        fill_row_rand();
        foreach (vec_m[i]) vec_m[i] = 0;
        begin
            int picks [4] = '{0, 7, 8, 1023};
            foreach (picks[p]) begin
                foreach (vec_m[i]) vec_m[i] = 0;
                vec_m[picks[p]] = 1;
                do_run(NB, 1'b0, 1'b0, -1, 0, "R2 one-hot");
            end
        end

        // R4: extremes on both sign paths, full length (R10 upper bound)
        foreach (row_m[i]) row_m[i] = -8;
        write_row();
        foreach (vec_m[i]) vec_m[i] = -8;
        do_run(NB, 1'b0, 1'b0, -1, 0, "R4 R10 max positive");
        foreach (vec_m[i]) vec_m[i] = 7;
        do_run(NB, 1'b0, 1'b0, -1, 0, "R4 max negative");

        // R10 lower bound and R5 beat sampling on a random row
        fill_row_rand();
        fill_vec_rand();
        do_run(1, 1'b0, 1'b0, -1, 0, "R10 R5 single beat");

        // R8: start in mid-run is ignored
        fill_vec_rand();
        do_run(20, 1'b0, 1'b0, 5, 3, "R8 mid-run start");

        // R8: back-to-back start in the pulse cycle is accepted
        fill_vec_rand();
        do_run(10, 1'b0, 1'b1, -1, 0, "R8 first of pair");
        fill_vec_rand();
        do_run(6, 1'b1, 1'b0, -1, 0, "R8 second of pair");

        // R9: illegal lengths, then a normal run
        bad_start(0);
        bad_start(129);
        fill_vec_rand();
        do_run(9, 1'b0, 1'b0, -1, 0, "R9 recovery");

        // R3 R5: constrained random runs
        for (int r = 0; r < 24; r++) begin
            if (r % 6 == 0) fill_row_rand();
            fill_vec_rand();
            do_run(int'($urandom_range(1, NB)), 1'b0, 1'b0, -1, 0, "R3 R5 random");
        end

        repeat (3) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule